// File: doc/BRIEF.md
# Float64 Reciprocal Square Root Unit

This block takes one IEEE-754 binary64 operand per cycle and, a fixed number of cycles later, returns an approximation of one over its square root, together with an invalid-operation flag and a divide-by-zero flag. The normal path picks a starting estimate from a constant table. The table is addressed by the parity of the unbiased exponent and the leading fraction bits. Two Newton-Raphson steps in 60-bit fixed point then refine the estimate.

Special operands bypass the arithmetic. Subnormal inputs are treated as zero with their sign kept. NaNs pass through with the quiet bit forced to one. Negative operands produce the default quiet NaN. Zeros produce an infinity of the same sign. Positive infinity produces positive zero. Even powers of two give an exact result.

The unit has a single valid bit on each side and no back-pressure. A new operand may enter on every cycle, and every accepted operand leaves exactly five cycles later.

Top module: `rsqrt_f64`

## Requirements
- R1: For every positive normal input that is not an even power of two, the result is a positive normal number whose relative error from 1/sqrt(x) is below 2^-28, and both flags are low.
- R2: An input of exactly 2^(-2n) gives exactly 2^n: fraction field zero and biased exponent 1023+n. Both flags are low.
- R3: A NaN input (exponent all ones, fraction non-zero) returns the same bits with fraction bit 51 set. The invalid flag is high only if fraction bit 51 of the input was 0 (a signalling NaN). The NaN rule comes before the sign rule.
- R4: A negative input that is neither zero nor subnormal, including negative infinity, returns 64'hFFF8_0000_0000_0000 and raises the invalid flag.
- R5: Positive zero and positive subnormals (exponent field 0) return 64'h7FF0_0000_0000_0000 and raise the divide-by-zero flag.
- R6: Negative zero and negative subnormals return 64'hFFF0_0000_0000_0000 and raise the divide-by-zero flag.
- R7: Positive infinity returns 64'h0 with both flags low.
- R8: Each input with in_valid high yields exactly one result with out_valid high five clock edges later, with no output in between. Inputs on consecutive cycles give results on consecutive cycles, in the same order.
- R9: The flags are low whenever out_valid is low, and at most one flag is high at a time.
- R10: While reset is held, and on the first cycle after it, out_valid and both flags are low. An operand accepted before reset never appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand on in_x is presented this cycle |
| in_x | input | 64 | Binary64 operand |
| out_valid | output | 1 | Result on out_y is valid this cycle |
| out_y | output | 64 | Binary64 approximation of 1/sqrt(in_x) |
| out_invalid | output | 1 | Invalid-operation flag for the current result |
| out_divzero | output | 1 | Divide-by-zero flag for the current result |

## Verification
The latency property assumes in_valid is a known 0 or 1 on every clock edge after reset. The output checks assume in_x holds a known value whenever in_valid is high. The stimulus meets both conditions: it changes inputs only on falling edges, keeps in_valid low except during deliberate issue cycles, and never leaves in_x undriven. Reset is asserted while an operand is in flight, because the latency property only starts counting after reset, and a flushed operand must not surface.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

    // Fixed-point fraction bits used by the refinement datapath.
    localparam int FRAC_W      = 60;
    // Leading fraction bits that address the seed table.
    localparam int SEED_IDX_W  = 7;
    // Fraction bits stored per seed entry.
    localparam int SEED_FRAC_W = 20;

    localparam int A_W     = FRAC_W + 2;      // scaled mantissa in [1,4)
    localparam int Y_W     = FRAC_W + 1;      // estimate in (0.5,1]
    localparam int IDX_W   = SEED_IDX_W + 1;  // parity bit + fraction bits
    localparam int LATENCY = 5;

    localparam logic [63:0] QNAN_DEFAULT = 64'hFFF8_0000_0000_0000;

    typedef struct packed {
        logic        vld;
        logic        spec;
        logic [63:0] spec_val;
        logic        inv;
        logic        dz;
        logic        exact;
        logic [10:0] res_exp;
    } meta_t;

    typedef struct packed {
        meta_t            meta;
        logic [A_W-1:0]   a;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        meta_t          meta;
        logic [A_W-1:0] a;
        logic [Y_W-1:0] y;
    } iter_t;

    typedef struct packed {
        meta_t          meta;
        logic [Y_W-1:0] y;
    } fin_t;

    typedef struct packed {
        logic        vld;
        logic [63:0] y;
        logic        inv;
        logic        dz;
    } res_t;

    typedef struct packed {
        dec_t  dec;
        iter_t seed;
        iter_t it1;
        fin_t  it2;
        res_t  res;
    } pipe_t;

    // Seed for one table slot: floor(2^frac_bits / sqrt(midpoint)), where the
    // midpoint is the centre of the mantissa interval the slot covers. The top
    // index bit selects the doubled mantissa range [2,4).
    function automatic logic [63:0] seed_value(int unsigned index, int idx_bits,
                                               int frac_bits);
        logic [63:0] mid;
        logic [63:0] tgt;
        logic [63:0] est;
        logic [63:0] cand;
        int          k;
        logic [63:0] top;
        k    = idx_bits - 1;
        top  = 64'(index) & ((64'd1 << k) - 64'd1);
        mid  = (64'd1 << (k + 1)) + (top << 1) + 64'd1;
        if (((index >> k) & 1) != 0) begin
            mid = mid << 1;
        end
        tgt = 64'd1 << (2 * frac_bits + k + 1);
        est = 64'd0;
        for (int b = frac_bits; b >= 0; b--) begin
            cand = est | (64'd1 << b);
            if (cand * cand * mid <= tgt) begin
                est = cand;
            end
        end
        return est;
    endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
    import rsqrt_pkg::*;
#(
    parameter int FRAC    = FRAC_W,
    parameter int IDX_FR  = SEED_IDX_W
) (
    input  logic              valid,
    input  logic [63:0]       x,
    output meta_t             meta,
    output logic [FRAC+1:0]   a,
    output logic [IDX_FR:0]   idx
);

    logic               sgn;
    logic [10:0]        bexp;
    logic [51:0]        frac;
    logic               is_nan;
    logic               is_inf;
    logic               is_zero;
    logic               odd_e;
    logic signed [12:0] e_adj;
    logic signed [12:0] half;

    always_comb begin
        sgn     = x[63];
        bexp    = x[62:52];
        frac    = x[51:0];
        is_nan  = (&bexp) && (|frac);
        is_inf  = (&bexp) && !(|frac);
        is_zero = (bexp == 11'd0);          // subnormals flushed to zero
        odd_e   = ~bexp[0];                 // even biased exponent -> odd unbiased

        e_adj = 13'(bexp) - 13'd1023 - 13'(odd_e);
        half  = e_adj >>> 1;

        meta          = '0;
        meta.vld      = valid;
        meta.exact    = !odd_e && (frac == 52'd0);
        meta.res_exp  = 11'((meta.exact ? 13'd1023 : 13'd1022) - half);

        if (is_nan) begin
            meta.spec     = 1'b1;
            meta.spec_val = x | (64'd1 << 51);
            meta.inv      = ~frac[51];
        end else if (is_zero) begin
            meta.spec     = 1'b1;
            meta.spec_val = {sgn, 11'h7FF, 52'd0};
            meta.dz       = 1'b1;
        end else if (sgn) begin
            meta.spec     = 1'b1;
            meta.spec_val = QNAN_DEFAULT;
            meta.inv      = 1'b1;
        end else if (is_inf) begin
            meta.spec     = 1'b1;
            meta.spec_val = 64'd0;
        end

        if (odd_e) begin
            a = {1'b1, frac, {(FRAC - 51){1'b0}}};
        end else begin
            a = {2'b01, frac, {(FRAC - 52){1'b0}}};
        end
        idx = {odd_e, frac[51 -: IDX_FR]};
    end

endmodule

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom
    import rsqrt_pkg::*;
#(
    parameter int IDX_BITS = IDX_W,
    parameter int OUT_FRAC = SEED_FRAC_W
) (
    input  logic [IDX_BITS-1:0] idx,
    output logic [OUT_FRAC:0]   seed
);

    localparam int DEPTH = 1 << IDX_BITS;

    logic [OUT_FRAC:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [OUT_FRAC:0] VAL =
            (OUT_FRAC + 1)'(seed_value(g, IDX_BITS, OUT_FRAC));
        assign rom[g] = VAL;
    end

    assign seed = rom[idx];

endmodule

// File: rtl/rsqrt_nr_step.sv
module rsqrt_nr_step #(
    parameter int FRAC = rsqrt_pkg::FRAC_W
) (
    input  logic [FRAC+1:0] a,
    input  logic [FRAC:0]   y,
    output logic [FRAC:0]   y_next
);

    localparam int PW = 2 * FRAC + 4;

    logic [PW-1:0] yy;
    logic [PW-1:0] t;
    logic [PW-1:0] at;
    logic [PW-1:0] u;
    logic [PW-1:0] v;
    logic [PW-1:0] yv;

    // y_next = y * (3 - a*y*y) / 2, all values scaled by 2^FRAC
    always_comb begin
        yy     = PW'(y) * PW'(y);
        t      = yy >> FRAC;
        at     = PW'(a) * t;
        u      = at >> FRAC;
        v      = (PW'(3) << FRAC) - u;
        yv     = PW'(y) * v;
        y_next = (FRAC + 1)'(yv >> (FRAC + 1));
    end

endmodule

// File: rtl/rsqrt_f64.sv
module rsqrt_f64
    import rsqrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_x,
    output logic        out_valid,
    output logic [63:0] out_y,
    output logic        out_invalid,
    output logic        out_divzero
);

    pipe_t pipe_d;
    pipe_t pipe_q;

    meta_t                dec_meta;
    logic [A_W-1:0]       dec_a;
    logic [IDX_W-1:0]     dec_idx;
    logic [SEED_FRAC_W:0] seed_w;
    logic [Y_W-1:0]       nr1_y;
    logic [Y_W-1:0]       nr2_y;

    rsqrt_classify #(.FRAC(FRAC_W), .IDX_FR(SEED_IDX_W)) i_classify (
        .valid (in_valid),
        .x     (in_x),
        .meta  (dec_meta),
        .a     (dec_a),
        .idx   (dec_idx)
    );

    rsqrt_seed_rom #(.IDX_BITS(IDX_W), .OUT_FRAC(SEED_FRAC_W)) i_seed_rom (
        .idx  (pipe_q.dec.idx),
        .seed (seed_w)
    );

    rsqrt_nr_step #(.FRAC(FRAC_W)) i_nr_first (
        .a      (pipe_q.seed.a),
        .y      (pipe_q.seed.y),
        .y_next (nr1_y)
    );

    rsqrt_nr_step #(.FRAC(FRAC_W)) i_nr_second (
        .a      (pipe_q.it1.a),
        .y      (pipe_q.it1.y),
        .y_next (nr2_y)
    );

    logic [51:0] mant;

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: decode
        pipe_d.dec.meta = dec_meta;
        pipe_d.dec.a    = dec_a;
        pipe_d.dec.idx  = dec_idx;

        // stage 2: seed
        pipe_d.seed.meta = pipe_q.dec.meta;
        pipe_d.seed.a    = pipe_q.dec.a;
        pipe_d.seed.y    = Y_W'(seed_w) << (FRAC_W - SEED_FRAC_W);

        // stage 3: first refinement
        pipe_d.it1.meta = pipe_q.seed.meta;
        pipe_d.it1.a    = pipe_q.seed.a;
        pipe_d.it1.y    = nr1_y;

        // stage 4: second refinement
        pipe_d.it2.meta = pipe_q.it1.meta;
        pipe_d.it2.y    = nr2_y;

        // stage 5: normalise and pack
        if (pipe_q.it2.meta.exact) begin
            mant = 52'd0;
        end else if (pipe_q.it2.y[FRAC_W]) begin
            mant = '1;                               // saturate just below 1
        end else if (!pipe_q.it2.y[FRAC_W-1]) begin
            mant = 52'd0;                            // clamp to 0.5
        end else begin
            mant = pipe_q.it2.y[FRAC_W-2 -: 52];
        end

        pipe_d.res.vld = pipe_q.it2.meta.vld;
        pipe_d.res.inv = pipe_q.it2.meta.vld && pipe_q.it2.meta.inv;
        pipe_d.res.dz  = pipe_q.it2.meta.vld && pipe_q.it2.meta.dz;
        if (pipe_q.it2.meta.spec) begin
            pipe_d.res.y = pipe_q.it2.meta.spec_val;
        end else begin
            pipe_d.res.y = {1'b0, pipe_q.it2.meta.res_exp, mant};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid   = pipe_q.res.vld;
    assign out_y       = pipe_q.res.y;
    assign out_invalid = pipe_q.res.inv;
    assign out_divzero = pipe_q.res.dz;

endmodule

// File: rtl/rsqrt_f64_chk.sv
module rsqrt_f64_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [63:0] out_y,
    input logic        out_invalid,
    input logic        out_divzero
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 3'd0;
        end else if (since_rst != 3'd5) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));   // R8

    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_invalid && !out_divzero));                // R9

    AST_FLAGS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_invalid, out_divzero}) <= 1));  // R9

    AST_DZ_INFINITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_divzero) |-> (out_y[62:0] == 63'h7FF0_0000_0000_0000)); // R5

    AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (&out_y[62:51]));               // R4

    AST_FINITE_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_divzero && !(&out_y[62:52])) |-> !out_y[63]); // R1

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);                                  // R10

endmodule

bind rsqrt_f64 rsqrt_f64_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_y       (out_y),
    .out_invalid (out_invalid),
    .out_divzero (out_divzero)
);

// File: tb/test_rsqrt_f64.sv
`timescale 1ns/1ps
module test_rsqrt_f64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_x = 64'd0;
    logic        out_valid;
    logic [63:0] out_y;
    logic        out_invalid;
    logic        out_divzero;

    int n_tests = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsqrt_f64 i_rsqrt_f64 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_x        (in_x),
        .out_valid   (out_valid),
        .out_y       (out_y),
        .out_invalid (out_invalid),
        .out_divzero (out_divzero)
    );

    // approx: 1 -> tolerance check against 1/sqrt(x), 0 -> exact bits
    typedef struct packed {
        logic [63:0] x;
        logic [63:0] y;
        logic        approx;
        logic        inv;
        logic        dz;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 1 -> 1
        '{64'h3FD0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 0.25 -> 2
        '{64'h4010_0000_0000_0000, 64'h3FE0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 4 -> 0.5
        '{64'h3F30_0000_0000_0000, 64'h4050_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 2^-12 -> 64
        '{64'h0010_0000_0000_0000, 64'h5FE0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 2^-1022
        '{64'h7FD0_0000_0000_0000, 64'h2000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 2^1022
        '{64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 +inf
        '{64'h0000_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 +0
        '{64'h000F_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 +subnormal
        '{64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 -0
        '{64'h8000_0000_0000_0001, 64'hFFF0_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 -subnormal
        '{64'hBFF0_0000_0000_0000, 64'hFFF8_0000_0000_0000, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 -1
        '{64'hFFF0_0000_0000_0000, 64'hFFF8_0000_0000_0000, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 -inf
        '{64'h7FF8_0000_0000_1234, 64'h7FF8_0000_0000_1234, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 quiet NaN
        '{64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 signalling NaN
        '{64'hFFF4_0000_0000_0000, 64'hFFFC_0000_0000_0000, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 negative sNaN
        '{64'h4000_0000_0000_0000, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 2.0
        '{64'h4008_0000_0000_0000, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 3.0
        '{64'h3FF0_0000_0000_0001, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 1+ulp
        '{64'h400F_FFFF_FFFF_FFFF, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 just under 4
        '{64'h7FEF_FFFF_FFFF_FFFF, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 max normal
        '{64'h4024_0000_0000_0000, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 10.0
        '{64'h3FB9_9999_9999_999A, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}, // R1 0.1
        '{64'h3FF7_FFFF_FFFF_FFFF, 64'h0,                  1'b1, 1'b0, 1'b0, 4'd1}  // R1 ~1.5
    };

    localparam real TOL = 3.725290298461914e-9;   // 2^-28

    task automatic check(input bit ok, input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_result(input vec_t v);
        real got;
        real want;
        real rel;
        check(out_valid === 1'b1, 8, "out_valid at latency", 64'(out_valid), 64'd1);
        check(out_invalid === v.inv, int'(v.req), "invalid flag", 64'(out_invalid), 64'(v.inv));
        check(out_divzero === v.dz, int'(v.req), "divzero flag", 64'(out_divzero), 64'(v.dz));
        if (v.approx) begin
            got  = $bitstoreal(out_y);
            want = 1.0 / $sqrt($bitstoreal(v.x));
            rel  = (got > want) ? (got - want) / want : (want - got) / want;
            check(rel < TOL && out_y[63] == 1'b0, int'(v.req), "relative error",
                  out_y, $realtobits(want));
        end else begin
            check(out_y === v.y, int'(v.req), "result bits", out_y, v.y);
        end
    endtask

    task automatic issue_one(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = v.x;
        @(negedge clk);
        in_valid = 1'b0;
        in_x     = 64'd0;
        repeat (3) @(negedge clk);
        // R8: nothing before the fifth edge; R9: flags quiet while idle
        check(out_valid === 1'b0, 8, "early out_valid", 64'(out_valid), 64'd0);
        check(!out_invalid && !out_divzero, 9, "idle flags",
              {62'd0, out_invalid, out_divzero}, 64'd0);
        @(negedge clk);
        check_result(v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid === 1'b0 && out_invalid === 1'b0 && out_divzero === 1'b0, 10,
              "outputs in reset", {61'd0, out_valid, out_invalid, out_divzero}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, 10, "first cycle after reset", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue_one(VECS[i]);
        end

        // R8: back-to-back issue keeps order and spacing
        @(negedge clk);
        in_valid = 1'b1; in_x = VECS[1].x;
        @(negedge clk);
        in_x = VECS[7].x;
        @(negedge clk);
        in_x = VECS[11].x;
        @(negedge clk);
        in_valid = 1'b0; in_x = 64'd0;
        repeat (2) @(negedge clk);
        check_result(VECS[1]);
        @(negedge clk);
        check_result(VECS[7]);
        @(negedge clk);
        check_result(VECS[11]);
        @(negedge clk);
        check(out_valid === 1'b0, 8, "burst trailing idle", 64'(out_valid), 64'd0);

        // R10: operand in flight is dropped by reset
        @(negedge clk);
        in_valid = 1'b1; in_x = VECS[2].x;
        @(negedge clk);
        in_valid = 1'b0; in_x = 64'd0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(out_valid === 1'b0, 10, "flushed operand surfaced", 64'(out_valid), 64'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
            $finish;
        end
    end

endmodule